// File: doc/BRIEF.md
# Three-Mode Pulse and Delay Timer

This block is a single timing engine with three behaviours chosen by a static mode input: a one-shot pulse that cannot be retriggered, an on-delay that keeps its output low until the input has stayed high for a preset time, and an off-delay that keeps its output high until the input has stayed low for a preset time. Time is counted in ticks. A one-cycle `tick` strobe from an external time base advances the elapsed count. The preset is captured when each timing session starts, so later changes on the preset input affect only the next session.

The elapsed-time output shows how far the current session has run. It stops at the captured preset and keeps its last value after completion, until the next session clears it. The mode input is meant to be set while the block is in reset and left unchanged afterwards. All outputs come straight from registers.

Top module: `multi_mode_timer`

## Requirements
- R1: While `rstN` is low, `qOut` is 0 and `elapsed` is 0.
- R2: Pulse mode (`modeSel`=0). A 0-to-1 change on `trigIn` with a nonzero preset clears `elapsed` and raises `qOut` at the next clock. `qOut` stays high until `elapsed` reaches the captured preset.
- R3: Pulse mode. While a pulse session is running, changes on `trigIn` have no effect. After the session ends, a new 0-to-1 change on `trigIn` is needed to start another.
- R4: Pulse mode. If `trigIn` is still high when `elapsed` reaches the preset, `qOut` stays high until the clock after `trigIn` goes low. Otherwise `qOut` falls on the clock where the preset is reached.
- R5: On-delay mode (`modeSel`=1). `trigIn` high starts timing from 0. `qOut` rises on the clock where `elapsed` reaches the preset and falls on the clock after `trigIn` goes low.
- R6: On-delay mode. If `trigIn` goes low before the preset is reached, `elapsed` returns to 0 and `qOut` stays low.
- R7: Off-delay mode (`modeSel`=2). `trigIn` high raises `qOut` at the next clock and clears `elapsed`. When `trigIn` goes low, timing starts, and `qOut` falls on the clock where `elapsed` reaches the preset.
- R8: Off-delay mode. If `trigIn` goes high again before the preset is reached, `elapsed` returns to 0 and `qOut` stays high.
- R9: `elapsed` rises by exactly one only on a clock where `tick` is 1 and a session is timing. It never exceeds the preset captured at session start, and it keeps its final value after completion until the next session starts. A change on `preset` during a session has no effect on that session.
- R10: A preset of 0 completes at once. Pulse mode gives no `qOut` pulse. On-delay raises `qOut` at the clock after `trigIn` goes high. Off-delay drops `qOut` at the clock after `trigIn` goes low.
- R11: `modeSel`=3 is an idle code: `qOut` stays 0 and `elapsed` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle time-base strobe |
| trigIn | input | 1 | Timer input signal |
| modeSel | input | 2 | 0 pulse, 1 on-delay, 2 off-delay, 3 idle |
| preset | input | CNT_W | Duration in ticks, captured at session start |
| qOut | output | 1 | Timer output |
| elapsed | output | CNT_W | Ticks elapsed in the current or last session |

## Verification
The two events that can land on the same clock are the final tick that completes a session and a change on `trigIn`. When they coincide, the result decides whether the pulse holds after completion, whether the on-delay fires or clears, and whether the off-delay drops or re-arms. The bench drives random `trigIn` toggles against random tick strobes so that these cases happen many times in every mode, including a change of `trigIn` on the very tick that reaches the preset. A behavioural reference model predicts `qOut` and `elapsed` for every cycle, and the bench compares them after each clock edge.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam logic [1:0] MODE_PULSE = 2'd0;
  localparam logic [1:0] MODE_ON    = 2'd1;
  localparam logic [1:0] MODE_OFF   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } phase_t;

  typedef struct packed {
    logic clrEt;
    logic incEt;
    logic loadPt;
  } strobe_t;
endpackage

// File: rtl/mmt_datapath.sv
module mmt_datapath
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [CNT_W-1:0] preset,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] etVal,
  output logic             rise,
  output logic             hitNext,
  output logic             presetZero
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] etReg;
  logic [CNT_W-1:0] ptReg;
  logic             prevIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      etReg  <= '0;
      ptReg  <= '0;
      prevIn <= 1'b0;
    end else begin
      prevIn <= trigIn;
      if (strb.clrEt)      etReg <= '0;
      else if (strb.incEt) etReg <= etReg + ONE;
      if (strb.loadPt)     ptReg <= preset;
    end
  end

  assign etVal      = etReg;
  assign rise       = trigIn & ~prevIn;
  assign hitNext    = ((etReg + ONE) == ptReg);
  assign presetZero = (preset == '0);

  AST_ET_WITHIN_PT: assert property (@(posedge clk) disable iff (!rstN)
    etReg <= ptReg); // R9
  AST_ET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incEt && !strb.clrEt) |=> $stable(etReg)); // R9
  AST_PT_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPt |=> $stable(ptReg)); // R9
endmodule

// File: rtl/mmt_control.sv
module mmt_control
  import mmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       trigIn,
  input  logic       tick,
  input  logic       rise,
  input  logic       hitNext,
  input  logic       presetZero,
  output strobe_t    strb,
  output logic       qOut
);
  phase_t state, stateNxt;
  logic   qReg, qNxt;

  always_comb begin
    stateNxt = state;
    qNxt     = qReg;
    strb     = '0;
    unique case (modeSel)
      MODE_PULSE: begin
        unique case (state)
          ST_IDLE: if (rise) begin
            strb.loadPt = 1'b1;
            strb.clrEt  = 1'b1;
            if (!presetZero) begin
              stateNxt = ST_RUN;
              qNxt     = 1'b1;
            end
          end
          ST_RUN: if (tick) begin
            strb.incEt = 1'b1;
            if (hitNext) begin
              stateNxt = trigIn ? ST_HOLD : ST_IDLE;
              qNxt     = trigIn;
            end
          end
          default: if (!trigIn) begin
            stateNxt = ST_IDLE;
            qNxt     = 1'b0;
          end
        endcase
      end
      MODE_ON: begin
        unique case (state)
          ST_IDLE: if (trigIn) begin
            strb.loadPt = 1'b1;
            strb.clrEt  = 1'b1;
            if (presetZero) begin
              stateNxt = ST_HOLD;
              qNxt     = 1'b1;
            end else begin
              stateNxt = ST_RUN;
            end
          end
          ST_RUN: begin
            if (!trigIn) begin
              stateNxt   = ST_IDLE;
              strb.clrEt = 1'b1;
            end else if (tick) begin
              strb.incEt = 1'b1;
              if (hitNext) begin
                stateNxt = ST_HOLD;
                qNxt     = 1'b1;
              end
            end
          end
          default: if (!trigIn) begin
            stateNxt = ST_IDLE;
            qNxt     = 1'b0;
          end
        endcase
      end
      MODE_OFF: begin
        unique case (state)
          ST_IDLE: if (trigIn) begin
            stateNxt   = ST_HOLD;
            qNxt       = 1'b1;
            strb.clrEt = 1'b1;
          end
          ST_RUN: begin
            if (trigIn) begin
              stateNxt   = ST_HOLD;
              strb.clrEt = 1'b1;
            end else if (tick) begin
              strb.incEt = 1'b1;
              if (hitNext) begin
                stateNxt = ST_IDLE;
                qNxt     = 1'b0;
              end
            end
          end
          default: if (!trigIn) begin
            strb.loadPt = 1'b1;
            strb.clrEt  = 1'b1;
            if (presetZero) begin
              stateNxt = ST_IDLE;
              qNxt     = 1'b0;
            end else begin
              stateNxt = ST_RUN;
            end
          end
        endcase
      end
      default: begin
        stateNxt   = ST_IDLE;
        qNxt       = 1'b0;
        strb.clrEt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      qReg  <= 1'b0;
    end else begin
      state <= stateNxt;
      qReg  <= qNxt;
    end
  end

  assign qOut = qReg;

  AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_PULSE && state == ST_RUN) |-> qReg); // R2
  AST_ON_EARLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_ON && state == ST_RUN && !trigIn) |=> (!qReg && state == ST_IDLE)); // R6
  AST_OFF_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_OFF && state == ST_RUN && trigIn) |=> (qReg && state == ST_HOLD)); // R8
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd3) |=> !qReg); // R11
endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             trigIn,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] preset,
  output logic             qOut,
  output logic [CNT_W-1:0] elapsed
);
  strobe_t strb;
  logic    rise, hitNext, presetZero;

  mmt_control u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .trigIn(trigIn), .tick(tick),
    .rise(rise), .hitNext(hitNext), .presetZero(presetZero),
    .strb(strb), .qOut(qOut)
  );

  mmt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .preset(preset), .strb(strb),
    .etVal(elapsed), .rise(rise), .hitNext(hitNext), .presetZero(presetZero)
  );
endmodule

// File: tb/sim_multi_mode_timer.sv
`timescale 1ns/1ps
module sim_multi_mode_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tick = 1'b0;
  logic         trigIn = 1'b0;
  logic [1:0]   modeSel = 2'd0;
  logic [W-1:0] preset = '0;
  logic         qOut;
  logic [W-1:0] elapsed;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  multi_mode_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .trigIn(trigIn), .modeSel(modeSel),
    .preset(preset), .qOut(qOut), .elapsed(elapsed)
  );

  // Behavioural reference: stage 0 waiting, 1 timing, 2 holding/armed
  int  refQ = 0, refEt = 0, refPt = 0, stage = 0;
  bit  lastIn = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      refQ = 0; refEt = 0; refPt = 0; stage = 0; lastIn = 0;
    end else begin
      case (modeSel)
        2'd0: begin // pulse: R2 R3 R4 R10
          if (stage == 0) begin
            if (trigIn && !lastIn) begin
              refPt = int'(preset); refEt = 0;
              if (refPt != 0) begin stage = 1; refQ = 1; end
            end
          end else if (stage == 1) begin
            if (tick) begin
              refEt++;
              if (refEt == refPt) begin stage = trigIn ? 2 : 0; refQ = trigIn; end
            end
          end else if (!trigIn) begin stage = 0; refQ = 0; end
        end
        2'd1: begin // on-delay: R5 R6 R10
          if (stage == 0) begin
            if (trigIn) begin
              refPt = int'(preset); refEt = 0;
              if (refPt == 0) begin stage = 2; refQ = 1; end else stage = 1;
            end
          end else if (stage == 1) begin
            if (!trigIn) begin stage = 0; refEt = 0; end
            else if (tick) begin
              refEt++;
              if (refEt == refPt) begin stage = 2; refQ = 1; end
            end
          end else if (!trigIn) begin stage = 0; refQ = 0; end
        end
        2'd2: begin // off-delay: R7 R8 R10
          if (stage == 0) begin
            if (trigIn) begin stage = 2; refQ = 1; refEt = 0; end
          end else if (stage == 2) begin
            if (!trigIn) begin
              refPt = int'(preset); refEt = 0;
              if (refPt == 0) begin stage = 0; refQ = 0; end else stage = 1;
            end
          end else begin
            if (trigIn) begin stage = 2; refEt = 0; end
            else if (tick) begin
              refEt++;
              if (refEt == refPt) begin stage = 0; refQ = 0; end
            end
          end
        end
        default: begin refQ = 0; refEt = 0; stage = 0; end // R11
      endcase
      lastIn = trigIn;
    end
  end

  function automatic string tagOf(input logic [1:0] m);
    case (m)
      2'd0: return "R2 R3 R4 R9 R10";
      2'd1: return "R5 R6 R9 R10";
      2'd2: return "R7 R8 R9 R10";
      default: return "R11";
    endcase
  endfunction

  // Cycle compare against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (qOut !== refQ[0] || int'(elapsed) !== refEt) begin
        errors++;
        $display("FAIL %s cycle compare: q=%0d et=%0d expected q=%0d et=%0d",
                 tagOf(modeSel), qOut, elapsed, refQ, refEt);
      end
    end
  end

  task automatic named(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit i, input bit t);
    @(negedge clk); #1;
    trigIn = i; tick = t;
  endtask

  task automatic restart(input logic [1:0] m);
    @(negedge clk); #1;
    rstN = 1'b0; trigIn = 0; tick = 0; modeSel = m;
    repeat (2) @(negedge clk);
    named("R1 reset q", int'(qOut), 0);
    named("R1 reset et", int'(elapsed), 0);
    #1 rstN = 1'b1;
  endtask

  task automatic randomRun(input int n);
    for (int k = 0; k < n; k++) begin
      bit ni;
      ni = ($urandom_range(0, 5) == 0) ? ~trigIn : trigIn;
      if ($urandom_range(0, 9) == 0) preset = W'($urandom_range(0, 6));
      cyc(ni, bit'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    // R1 reset, then pulse mode
    restart(2'd0);
    preset = 3;
    cyc(1, 1);                         // rise seen at next edge
    @(negedge clk);
    named("R2 pulse q high", int'(qOut), 1);
    cyc(0, 1); cyc(1, 1);              // R3 toggles ignored
    preset = 9;                        // R9 change ignored mid-session
    cyc(1, 1);
    @(negedge clk);
    named("R4 pulse held while input high", int'(qOut), 1);
    named("R9 et stops at captured preset", int'(elapsed), 3);
    cyc(0, 0);
    @(negedge clk);
    named("R4 pulse drops after release", int'(qOut), 0);
    preset = 0; cyc(1, 1); cyc(1, 1);
    named("R10 zero preset gives no pulse", int'(qOut), 0);
    cyc(0, 0);
    randomRun(600);

    // on-delay
    restart(2'd1);
    preset = 2;
    cyc(1, 1); cyc(1, 1); cyc(0, 1);   // R6 release before preset
    @(negedge clk);
    named("R6 early release keeps q low", int'(qOut), 0);
    named("R6 early release clears et", int'(elapsed), 0);
    preset = 0; cyc(1, 0);
    @(negedge clk);
    named("R10 zero preset on-delay fires", int'(qOut), 1);
    cyc(0, 0);
    preset = 2;
    cyc(1, 1); cyc(1, 1); cyc(1, 1); cyc(1, 0);
    named("R5 on-delay output after preset", int'(qOut), 1);
    cyc(0, 0);
    randomRun(600);

    // off-delay
    restart(2'd2);
    preset = 3;
    cyc(1, 0);
    @(negedge clk);
    named("R7 off-delay q high at once", int'(qOut), 1);
    cyc(0, 1); cyc(0, 1); cyc(1, 1);  // R8 reassert before preset
    @(negedge clk);
    named("R8 reassert keeps q high", int'(qOut), 1);
    named("R8 reassert clears et", int'(elapsed), 0);
    cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(0, 0);
    named("R7 off-delay q falls", int'(qOut), 0);
    randomRun(600);

    // idle code
    restart(2'd3);
    randomRun(100);
    named("R11 idle code q", int'(qOut), 0);

    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule